// File: doc/BRIEF.md
# Chained-Descriptor Audio DMA Channel

This block is one DMA channel that streams audio samples between a memory buffer and a single peripheral data register. Software fills a small on-block descriptor RAM with a ring of segments, each naming a source address, a destination address, a byte count and the index of the following segment. Once started, the channel walks that ring forever, so a buffer split into periods plays or records without software restarting it. Every completed segment sets an end-of-segment status flag that can raise an interrupt; software uses that event to refill the period just consumed.

Each sample beat is a read followed by a write on one shared memory port, of 1, 2, 4 or 8 bytes. The peripheral side keeps a fixed address, adjusted for the byte lane a narrow sample occupies in a big-endian 32-bit register, while the memory side advances. Optionally, an external master paces the channel: bursts of a power-of-two byte count only begin when the peripheral asserts its request. Descriptor faults and bus errors halt the channel until software aborts it.

Top module: `audio_dma_chan`

## Requirements
- R1: Descriptor RAM word `4*i+0` holds source, `+1` destination, `+2` byte count, `+3` next index. After a segment's last beat the channel loads the descriptor named by the next index, so a ring whose last entry points to its first runs without end; the link register (address 2) selects the starting index.
- R2: Mode bit 2 selects the direction: 0 (playback) keeps the destination fixed and advances the source, 1 (capture) keeps the source fixed and advances the destination, each by the beat size after every beat.
- R3: Mode bits 4:3 give the beat size code 0, 1, 2, 3 for 1, 2, 4, 8 bytes; `mem_size` carries the code on both the read and the write, and the write data equals the data returned by the preceding read.
- R4: The fixed peripheral address is offset by 3 bytes for code 0, 2 bytes for code 1 and 0 bytes for codes 2 and 3.
- R5: Status bit 0 (end of segment) sets in the cycle after the segment's last write is accepted; writing 1 to a status bit at address 1 clears it, a set in the same cycle taking priority. `irq` follows bit 0 when mode bit 6 is 1 and stays 0 from it when mode bit 6 is 0.
- R6: With mode bit 5 set, each burst of 2^(mode bits 11:8) bytes (at least one beat) starts only on a cycle where `per_req` is 1; no memory access occurs while waiting.
- R7: A descriptor with a zero byte count, a count not a multiple of the beat size, or a next index outside the RAM sets status bit 2 and halts with no memory access.
- R8: `mem_err` on an accepted access sets status bit 1 and halts the channel; a start command is ignored until an abort.
- R9: Writing mode with bit 1 set aborts from any state; `mem_req` is 0 from the next cycle and the channel is idle (status bit 3, busy, reads 0).
- R10: Turning mode bit 5 on while the byte count register (address 3) is non-zero sets status bit 2 and halts instead of starting.
- R11: After reset the status reads 0, `irq` is 0 and `mem_req` is 0.
- R12: With mode bit 7 set, `irq` is 1 while status bit 1 or bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 link, 3 byte count |
| reg_wdata | input | 32 | Register write data; bit 0 of a mode write starts the channel |
| reg_rdata | output | 32 | Read data of the selected register |
| desc_we | input | 1 | Descriptor RAM write strobe |
| desc_addr | input | $clog2(NDESC)+2 | Descriptor RAM word address |
| desc_wdata | input | 32 | Descriptor RAM write data |
| mem_req | output | 1 | Memory access request, held until `mem_ready` |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ready` |
| per_req | input | 1 | Peripheral transfer request |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume the memory side never drops a pending request on its own account and answers `mem_err` only together with `mem_ready`, and that descriptors are rewritten only while the channel is idle. The stimulus honours this: the memory model in the bench accepts each request on the first cycle it sees it and raises an error only on an accepted access, and every descriptor update happens between an abort and the next start. A behavioural model in the bench follows the ring segment by segment and predicts each access address, size and data as well as the end-of-segment flag and interrupt on every cycle.

// File: rtl/audio_dma_chan.sv
module audio_dma_chan #(
  parameter int NDESC = 4,
  localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          desc_we,
  input  logic [IW+1:0] desc_addr,
  input  logic [31:0]   desc_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [1:0]    mem_size,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  input  logic          per_req,
  output logic          irq
);

  localparam logic [1:0]  A_MODE = 2'd0, A_STAT = 2'd1, A_LINK = 2'd2, A_CNT = 2'd3;
  localparam logic [31:0] MODE_KEEP = 32'h0000_0FFC;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_RD, S_WR, S_HALT} state_t;

  state_t      st;
  logic [31:0] dram [NDESC*4];
  logic [31:0] mode_q, src_q, dst_q, cnt_q, bleft_q;
  logic [IW-1:0] link_q, nxt_q;
  logic [63:0] data_q;
  logic        st_eos, st_te, st_pe;

  wire         dir_cap = mode_q[2];
  wire [1:0]   szc     = mode_q[4:3];
  wire         ext     = mode_q[5];
  wire [31:0]  nbytes  = 32'd1 << szc;
  wire [31:0]  lane    = (szc == 2'd0) ? 32'd3 : (szc == 2'd1) ? 32'd2 : 32'd0;
  wire [31:0]  d_src   = dram[{link_q, 2'd0}];
  wire [31:0]  d_dst   = dram[{link_q, 2'd1}];
  wire [31:0]  d_cnt   = dram[{link_q, 2'd2}];
  wire [31:0]  d_nxt   = dram[{link_q, 2'd3}];
  wire         d_bad   = (d_cnt == 32'd0) || ((d_cnt & (nbytes - 32'd1)) != 32'd0)
                         || (d_nxt >= 32'(NDESC));
  wire         mode_wr = reg_we && reg_addr == A_MODE;
  wire         abort_wr = mode_wr && reg_wdata[1];
  wire         busy    = st != S_IDLE && st != S_HALT;

  assign mem_req   = st == S_RD || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_size  = szc;
  assign mem_wdata = data_q;
  assign mem_addr  = (st == S_WR) ? (dir_cap ? dst_q : dst_q + lane)
                                  : (dir_cap ? src_q + lane : src_q);
  assign irq = (st_eos && mode_q[6]) || ((st_te || st_pe) && mode_q[7]);

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_STAT:  reg_rdata = {28'd0, busy, st_pe, st_te, st_eos};
      A_LINK:  reg_rdata = 32'(link_q);
      default: reg_rdata = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (desc_we) dram[desc_addr] <= desc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      bleft_q <= '0;
      link_q  <= '0;
      nxt_q   <= '0;
      data_q  <= '0;
      st_eos  <= 1'b0;
      st_te   <= 1'b0;
      st_pe   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_STAT) begin
        if (reg_wdata[0]) st_eos <= 1'b0;
        if (reg_wdata[1]) st_te  <= 1'b0;
        if (reg_wdata[2]) st_pe  <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (reg_we && reg_addr == A_LINK) link_q <= reg_wdata[IW-1:0];
          if (reg_we && reg_addr == A_CNT)  cnt_q  <= reg_wdata;
          if (mode_wr && !reg_wdata[1]) begin
            mode_q <= reg_wdata & MODE_KEEP;
            if (reg_wdata[5] && !mode_q[5] && cnt_q != 32'd0) begin
              st_pe <= 1'b1;
              st    <= S_HALT;
            end else if (reg_wdata[0]) begin
              st <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (d_bad) begin
            st_pe <= 1'b1;
            st    <= S_HALT;
          end else begin
            src_q <= d_src;
            dst_q <= d_dst;
            cnt_q <= d_cnt;
            nxt_q <= d_nxt[IW-1:0];
            st    <= ext ? S_WAIT : S_RD;
          end
        end
        S_WAIT: begin
          if (per_req) begin
            bleft_q <= 32'd1 << mode_q[11:8];
            st      <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ready) begin
            if (mem_err) begin
              st_te <= 1'b1;
              st    <= S_HALT;
            end else begin
              data_q <= mem_rdata;
              st     <= S_WR;
            end
          end
        end
        S_WR: begin
          if (mem_ready) begin
            if (mem_err) begin
              st_te <= 1'b1;
              st    <= S_HALT;
            end else begin
              cnt_q   <= cnt_q - nbytes;
              bleft_q <= bleft_q - nbytes;
              if (dir_cap) dst_q <= dst_q + nbytes;
              else         src_q <= src_q + nbytes;
              if (cnt_q == nbytes) begin
                st_eos <= 1'b1;
                link_q <= nxt_q;
                st     <= S_LOAD;
              end else if (ext && bleft_q <= nbytes) begin
                st <= S_WAIT;
              end else begin
                st <= S_RD;
              end
            end
          end
        end
        default: ;
      endcase
      if (abort_wr) st <= S_IDLE;
    end
  end

  // R2: a pending access keeps its address until accepted
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !abort_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_eos_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_eos) |-> $past(mem_req && mem_we && mem_ready && !mem_err));

  p_wait_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !per_req) |=> !mem_req);

  p_err_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_err) |=> (!mem_req && st_te));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!mem_req && !busy));

endmodule

// File: tb/audio_dma_chan_bench.sv
module audio_dma_chan_bench;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 2'd1; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic desc_we = 0; logic [3:0] desc_addr = 0; logic [31:0] desc_wdata = 0;
  logic mem_req, mem_we; logic [31:0] mem_addr; logic [1:0] mem_size; logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = 0; logic mem_ready = 0, mem_err = 0, per_req = 1;
  logic irq;

  audio_dma_chan #(.NDESC(4)) u_audio_dma_chan (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_acc = 0, n_wr = 0;
  bit inj_err = 0;

  // register port request from tasks
  bit rq_valid = 0; logic [1:0] rq_addr; logic [31:0] rq_data;

  // descriptors as written
  logic [31:0] bsrc [4], bdst [4], bcnt [4]; int bnxt [4];

  // reference model
  bit m_on = 0, m_dir = 0, m_phase = 0, m_segie = 0;
  int m_szc = 0, m_idx = 0, m_segs = 0;
  logic [31:0] m_src, m_dst, m_rem, m_rdaddr;
  bit m_eos = 0, eos_pend = 0, clr_pend = 0; int eos_age = 0;

  function automatic logic [63:0] mdata(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_load();
    m_src = bsrc[m_idx]; m_dst = bdst[m_idx]; m_rem = bcnt[m_idx];
  endtask

  always @(negedge clk) begin
    logic [31:0] ea, off, nb; bit ew;
    if (clr_pend) begin m_eos = 0; clr_pend = 0; end
    if (eos_pend) begin m_eos = 1; eos_pend = 0; eos_age = 0; end
    else if (m_eos) eos_age++;
    mem_ready = 0; mem_err = 0; mem_rdata = '0;
    if (mem_req) begin
      mem_ready = 1; mem_rdata = mdata(mem_addr);
      if (inj_err) begin mem_err = 1; inj_err = 0; end
      n_acc++; if (mem_we) n_wr++;
      if (m_on) begin
        off = (m_szc == 0) ? 3 : (m_szc == 1) ? 2 : 0;
        nb = 32'd1 << m_szc;
        ew = m_phase;
        if (!m_phase) ea = m_dir ? m_src + off : m_src;
        else          ea = m_dir ? m_dst : m_dst + off;
        chk(mem_we == ew && mem_addr == ea && int'(mem_size) == m_szc,
            "R1 R2 R3 R4 access", {mem_we, mem_size, mem_addr}, {ew, 2'(m_szc), ea});
        if (m_phase) chk(mem_wdata == mdata(m_rdaddr), "R3 data", mem_wdata, mdata(m_rdaddr));
        if (!m_phase) begin m_rdaddr = ea; m_phase = 1; end
        else begin
          m_phase = 0;
          if (m_dir) m_dst += nb; else m_src += nb;
          m_rem -= nb;
          if (m_rem == 0) begin
            eos_pend = 1; m_segs++; m_idx = bnxt[m_idx]; m_load();
          end
        end
      end
    end
    reg_we = 0; reg_addr = 2'd1;
    if (rq_valid) begin
      reg_we = 1; reg_addr = rq_addr; reg_wdata = rq_data; rq_valid = 0;
    end else if (m_on && m_eos && eos_age >= 1 && !clr_pend) begin
      reg_we = 1; reg_addr = 2'd1; reg_wdata = 32'd1; clr_pend = 1;
    end
    #2;
    if (m_on && !reg_we) begin
      chk(reg_rdata[2:0] == {2'b00, m_eos}, "R5 status", reg_rdata[2:0], {2'b00, m_eos});
      chk(irq == (m_eos && m_segie), "R5 irq", irq, m_eos && m_segie);
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    rq_addr = a; rq_data = d; rq_valid = 1;
    while (rq_valid) @(posedge clk);
  endtask

  task automatic rstat(output logic [31:0] v);
    @(negedge clk); #5; v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_desc(input int i, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input int nx);
    bsrc[i] = s; bdst[i] = d; bcnt[i] = c; bnxt[i] = nx;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      desc_we = 1; desc_addr = 4'(i * 4 + w);
      desc_wdata = (w == 0) ? s : (w == 1) ? d : (w == 2) ? c : 32'(nx);
    end
    @(negedge clk); desc_we = 0;
  endtask

  function automatic logic [31:0] mode(input int dir, input int szc, input int ext,
                                       input int segie, input int errie, input int bwc);
    return 32'((dir << 2) | (szc << 3) | (ext << 5) | (segie << 6) | (errie << 7) | (bwc << 8));
  endfunction

  task automatic start_stream(input int dir, input int szc, input int ext, input int segie,
                              input int bwc, input int idx);
    m_dir = dir[0]; m_szc = szc; m_segie = segie[0]; m_idx = idx; m_load();
    m_phase = 0; m_eos = 0; eos_pend = 0; clr_pend = 0; m_segs = 0;
    wreg(2'd2, 32'(idx));
    m_on = 1;
    wreg(2'd0, mode(dir, szc, ext, segie, 0, bwc) | 32'd1);
  endtask

  task automatic run_segs(input int n, input string tag);
    int t = 0;
    while (m_segs < n && t < 5000) begin @(posedge clk); t++; end
    chk(m_segs >= n, tag, m_segs, n);
  endtask

  task automatic stop_stream();
    m_on = 0;
    wreg(2'd0, 32'd2);
    wreg(2'd1, 32'd7);
    wreg(2'd3, 32'd0);
    wreg(2'd0, 32'd0);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  initial begin
    logic [31:0] v; int a0, w0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    rstat(v);
    chk(v == 32'd0, "R11 status", v, 0);
    chk(irq == 0, "R11 irq", irq, 0);
    chk(mem_req == 0, "R11 req", mem_req, 0);

    // playback, 2-byte samples, two-entry ring
    set_desc(0, 32'h1000, 32'h4000, 8, 1);
    set_desc(1, 32'h1100, 32'h4000, 6, 0);
    start_stream(0, 1, 0, 1, 0, 0);
    run_segs(5, "R1 ring wrap");
    stop_stream();

    // capture, 1-byte samples, three-entry ring starting at 1, no seg irq
    set_desc(1, 32'h5000, 32'h2000, 3, 2);
    set_desc(2, 32'h5000, 32'h2100, 5, 3);
    set_desc(3, 32'h5000, 32'h2200, 2, 1);
    start_stream(1, 0, 0, 0, 0, 1);
    run_segs(4, "R2 capture ring");
    stop_stream();

    // playback, 8-byte samples
    set_desc(0, 32'h3000, 32'h4400, 16, 1);
    set_desc(1, 32'h3800, 32'h4400, 24, 0);
    start_stream(0, 3, 0, 1, 0, 0);
    run_segs(4, "R4 eight byte");
    stop_stream();

    // capture, 4-byte samples, external master with request held high
    per_req = 1;
    set_desc(0, 32'h6000, 32'h7000, 12, 1);
    set_desc(1, 32'h6000, 32'h7100, 8, 0);
    start_stream(1, 2, 1, 1, 3, 0);
    run_segs(3, "R6 paced stream");
    stop_stream();

    // R6: burst gating by request pulses
    @(negedge clk); per_req = 0;
    set_desc(0, 32'h1200, 32'h4000, 16, 0);
    start_stream(0, 1, 1, 1, 2, 0);
    w0 = n_wr; wait_cyc(20);
    chk(n_wr - w0 == 0, "R6 no request", n_wr - w0, 0);
    @(negedge clk); per_req = 1; @(negedge clk); per_req = 0;
    wait_cyc(20);
    chk(n_wr - w0 == 2, "R6 one burst", n_wr - w0, 2);
    @(negedge clk); per_req = 1; @(negedge clk); per_req = 0;
    wait_cyc(20);
    chk(n_wr - w0 == 4, "R6 two bursts", n_wr - w0, 4);
    stop_stream();
    @(negedge clk); per_req = 1;

    // R7: zero count
    set_desc(0, 32'h1000, 32'h4000, 0, 0);
    a0 = n_acc;
    wreg(2'd2, 0);
    wreg(2'd0, mode(0, 1, 0, 0, 1, 0) | 32'd1);
    wait_cyc(10);
    rstat(v);
    chk(v == 32'd4, "R7 zero count", v, 4);
    chk(n_acc == a0, "R7 no access", n_acc - a0, 0);
    chk(irq == 1, "R12 irq on error", irq, 1);
    stop_stream();

    // R7: count not a multiple of 4-byte beat
    set_desc(0, 32'h1000, 32'h4000, 6, 0);
    a0 = n_acc;
    wreg(2'd0, mode(0, 2, 0, 0, 0, 0) | 32'd1);
    wait_cyc(10);
    rstat(v);
    chk(v == 32'd4, "R7 misaligned count", v, 4);
    chk(irq == 0, "R12 irq masked", irq, 0);
    chk(n_acc == a0, "R7 no access misaligned", n_acc - a0, 0);
    stop_stream();

    // R8: bus error on first read
    set_desc(0, 32'h1000, 32'h4000, 8, 0);
    a0 = n_acc; inj_err = 1;
    wreg(2'd0, mode(0, 1, 0, 0, 1, 0) | 32'd1);
    wait_cyc(10);
    rstat(v);
    chk(v == 32'd2, "R8 error status", v, 2);
    chk(n_acc - a0 == 1, "R8 halted", n_acc - a0, 1);
    chk(irq == 1, "R12 irq on bus error", irq, 1);
    wreg(2'd0, mode(0, 1, 0, 0, 1, 0) | 32'd1);
    wait_cyc(10);
    chk(n_acc - a0 == 1, "R8 start ignored", n_acc - a0, 1);
    wreg(2'd0, 32'd2);
    wreg(2'd1, 32'd2);
    rstat(v);
    chk(v == 32'd0, "R5 clear error bit", v, 0);
    chk(irq == 0, "R12 irq cleared", irq, 0);
    wreg(2'd0, mode(0, 1, 0, 0, 1, 0) | 32'd1);
    wait_cyc(10);
    chk(n_acc - a0 > 1, "R8 restart after abort", n_acc - a0, 2);
    stop_stream();

    // R9: abort mid-stream
    set_desc(0, 32'h1000, 32'h4000, 32, 0);
    start_stream(0, 0, 0, 1, 0, 0);
    run_segs(1, "R9 stream before abort");
    m_on = 0;
    wreg(2'd0, 32'd2);
    a0 = n_acc;
    wait_cyc(20);
    chk(n_acc == a0, "R9 no access after abort", n_acc - a0, 0);
    rstat(v);
    chk(v[3] == 0, "R9 idle", v[3], 0);
    stop_stream();

    // R10: external master with non-zero byte count
    wreg(2'd3, 32'd8);
    a0 = n_acc;
    wreg(2'd0, mode(0, 1, 1, 0, 0, 2) | 32'd1);
    wait_cyc(10);
    rstat(v);
    chk(v == 32'd4, "R10 count not zero", v, 4);
    chk(n_acc == a0, "R10 no access", n_acc - a0, 0);
    stop_stream();
    set_desc(0, 32'h1000, 32'h4000, 8, 0);
    start_stream(0, 1, 1, 1, 2, 0);
    run_segs(2, "R10 count zero starts");
    stop_stream();

    finish_up();
  end
endmodule